// File: doc/BRIEF.md
# Banked Interrupt and Reset Control Register

This block is the application interrupt and reset control word of a microcontroller interrupt controller that runs in two security states, secure and non-secure. Every 32-bit write carries a secure attribute and must hold a 16-bit unlock key in its upper half. A keyed write changes the priority-grouping field of the writer's own state. If the writer is secure, it also changes three secure-only configuration bits. A keyed write can also ask for a system reset.

Reads are combinational. The value returned depends on the attribute presented on the same cycle. The block drives a one-cycle system reset request and a one-cycle recompute strobe after every accepted write. It also drives a group-priority mask that the arbitration logic uses to split priorities into group and subpriority.

Two parameters select the configuration. `HAS_SECURITY` says whether the security extension exists; when it is 0, every access is treated as non-secure. `IS_V8` says whether non-secure readers can see the fault-routing bit.

Top module: `intc_app_ctrl_reg`

## Requirements
- R1: A write whose bits 31:16 differ from 0x05FA changes no state, raises no reset request and raises no recompute strobe.
- R2: A read returns 0xFA05 in bits 31:16 and, in bits 10:8, the grouping value of the security state presented on `secAttr`.
- R3: The grouping field (write bits 10:8) has one copy per security state, and a keyed write updates only the writer's copy.
- R4: Bit 3 (reset request secure-only), bit 13 (faults routed to non-secure) and bit 14 (secure priority boost) are updated only by keyed secure writes. Non-secure writes leave them unchanged.
- R5: A keyed write with bit 2 set drives `sysResetReq` high for exactly the cycle after the write. This happens only if the writer is secure or the stored bit 3 is clear before the write.
- R6: Secure reads return the stored bits 3, 13 and 14. Non-secure reads return bit 13 only when `IS_V8`=1, and read bits 3 and 14 as zero.
- R7: After reset, both grouping copies and bits 3 and 14 are 0. Bit 13 resets to 1 when `HAS_SECURITY`=0 (where it reads as one) and to 0 otherwise.
- R8: `prioMask` equals all-ones of width `MASK_W` shifted left by the non-secure grouping value plus one (0xFE for 0, 0x00 for 7 at width 8).
- R9: Bits 0 and 1 of a keyed write have no effect: no reset request and no state change beyond the other fields of that write.
- R10: Read bits 15, 12:11, 7:4, 2:0 are always zero, and writes to them are ignored.
- R11: `prioUpdate` is high for one cycle after every accepted keyed write and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| secAttr | input | 1 | Secure attribute of the current access (read or write) |
| wrData | input | 32 | Write data including the unlock key |
| rdData | output | 32 | Composed read value for the presented attribute |
| sysResetReq | output | 1 | One-cycle system reset request |
| prioUpdate | output | 1 | One-cycle strobe after an accepted write |
| prioMask | output | MASK_W | Group-priority mask from the non-secure grouping |

## Verification
The assertions assume that `wrEn` is a clean one-cycle strobe and that `wrData` and `secAttr` are stable at the sampling edge. They also assume that no write arrives while reset is asserted. The bench keeps to these assumptions. It drives every input on the falling edge, raises `wrEn` for one cycle per write, and separates writes by idle cycles so that each pulse and strobe is seen on its own. It samples reads only after the attribute has settled for a time step.

// File: rtl/intc_app_ctrl_pkg.sv
package intc_app_ctrl_pkg;
  localparam int KEY_W      = 16;
  localparam int POS_RSTREQ = 2;
  localparam int POS_RSTSEC = 3;
  localparam int POS_GRP    = 8;
  localparam int POS_FLTNS  = 13;
  localparam int POS_PRISEC = 14;

  typedef struct packed {
    logic updGrpSec;
    logic updGrpNs;
    logic updSecOnly;
    logic accepted;
  } ctlStrobes_t;

  typedef struct packed {
    logic priSec;
    logic faultToNs;
    logic rstSecOnly;
  } secCfg_t;
endpackage

// File: rtl/intc_app_ctrl_ctl.sv
module intc_app_ctrl_ctl
  import intc_app_ctrl_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1,
  parameter logic [KEY_W-1:0] WR_KEY = 16'h05FA
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             secAttr,
  input  logic [KEY_W-1:0] wrKey,
  input  logic             rstReqBit,
  input  logic             curRstSecOnly,
  output ctlStrobes_t      strb,
  output logic             sysResetReq,
  output logic             prioUpdate
);
  logic keyOk;
  logic effSec;
  logic rstAllowed;

  assign keyOk      = (wrKey == WR_KEY);
  assign effSec     = secAttr & HAS_SECURITY;
  assign rstAllowed = effSec | ~curRstSecOnly;

  always_comb begin
    strb            = '0;
    strb.accepted   = wrEn & keyOk;
    strb.updGrpSec  = wrEn & keyOk & effSec;
    strb.updGrpNs   = wrEn & keyOk & ~effSec;
    strb.updSecOnly = wrEn & keyOk & effSec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysResetReq <= 1'b0;
      prioUpdate  <= 1'b0;
    end else begin
      sysResetReq <= strb.accepted & rstReqBit & rstAllowed;
      prioUpdate  <= strb.accepted;
    end
  end

  a_r1_no_effect_without_key: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrKey != WR_KEY) |=> (!sysResetReq && !prioUpdate));

  a_r5_blocked_reset: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(secAttr && HAS_SECURITY) && curRstSecOnly) |=> !sysResetReq);

  a_r11_strobe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrKey == WR_KEY) |=> prioUpdate);

  a_r11_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !prioUpdate);
endmodule

// File: rtl/intc_app_ctrl_dp.sv
module intc_app_ctrl_dp
  import intc_app_ctrl_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1,
  parameter bit IS_V8        = 1'b1,
  parameter int GRP_W        = 3,
  parameter int MASK_W       = 8,
  parameter logic [KEY_W-1:0] RD_KEY = 16'hFA05
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              secAttr,
  input  logic [GRP_W-1:0]  wrGrp,
  input  secCfg_t           wrCfg,
  output logic [31:0]       rdData,
  output logic              curRstSecOnly,
  output logic [MASK_W-1:0] prioMask
);
  localparam int SH_W = GRP_W + 1;
  localparam secCfg_t CFG_RST = '{priSec: 1'b0, faultToNs: !HAS_SECURITY, rstSecOnly: 1'b0};

  logic [GRP_W-1:0] grpSec;
  logic [GRP_W-1:0] grpNs;
  secCfg_t          cfg;
  logic             rdSec;
  logic [SH_W-1:0]  shAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpSec <= '0;
      grpNs  <= '0;
      cfg    <= CFG_RST;
    end else begin
      if (strb.updGrpSec)  grpSec <= wrGrp;
      if (strb.updGrpNs)   grpNs  <= wrGrp;
      if (strb.updSecOnly) cfg    <= wrCfg;
    end
  end

  assign rdSec         = secAttr & HAS_SECURITY;
  assign curRstSecOnly = cfg.rstSecOnly;

  always_comb begin
    rdData                      = '0;
    rdData[31:16]               = RD_KEY;
    rdData[POS_GRP +: GRP_W]    = rdSec ? grpSec : grpNs;
    if (rdSec) begin
      rdData[POS_RSTSEC] = cfg.rstSecOnly;
      rdData[POS_FLTNS]  = cfg.faultToNs;
      rdData[POS_PRISEC] = cfg.priSec;
    end else if (IS_V8) begin
      rdData[POS_FLTNS]  = cfg.faultToNs;
    end
  end

  assign shAmt    = SH_W'(grpNs) + SH_W'(1);
  assign prioMask = {MASK_W{1'b1}} << shAmt;

  a_r3_sec_copy_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.updGrpSec |=> $stable(grpSec));

  a_r3_ns_copy_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.updGrpNs |=> $stable(grpNs));

  a_r4_secure_bits_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.updSecOnly |=> $stable(cfg));
endmodule

// File: rtl/intc_app_ctrl_reg.sv
module intc_app_ctrl_reg
  import intc_app_ctrl_pkg::*;
#(
  parameter bit HAS_SECURITY = 1'b1,
  parameter bit IS_V8        = 1'b1,
  parameter int GRP_W        = 3,
  parameter int MASK_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              secAttr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              sysResetReq,
  output logic              prioUpdate,
  output logic [MASK_W-1:0] prioMask
);
  localparam logic [31:0] RSVD_MASK = 32'h0000_98F7;

  ctlStrobes_t strb;
  secCfg_t     wrCfg;
  logic        curRstSecOnly;

  assign wrCfg = '{priSec:     wrData[POS_PRISEC],
                   faultToNs:  wrData[POS_FLTNS],
                   rstSecOnly: wrData[POS_RSTSEC]};

  intc_app_ctrl_ctl #(
    .HAS_SECURITY(HAS_SECURITY)
  ) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .secAttr      (secAttr),
    .wrKey        (wrData[31:16]),
    .rstReqBit    (wrData[POS_RSTREQ]),
    .curRstSecOnly(curRstSecOnly),
    .strb         (strb),
    .sysResetReq  (sysResetReq),
    .prioUpdate   (prioUpdate)
  );

  intc_app_ctrl_dp #(
    .HAS_SECURITY(HAS_SECURITY),
    .IS_V8       (IS_V8),
    .GRP_W       (GRP_W),
    .MASK_W      (MASK_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .secAttr      (secAttr),
    .wrGrp        (wrData[POS_GRP +: GRP_W]),
    .wrCfg        (wrCfg),
    .rdData       (rdData),
    .curRstSecOnly(curRstSecOnly),
    .prioMask     (prioMask)
  );

  a_r10_reserved_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RSVD_MASK) == 32'h0);
endmodule

// File: tb/sim_intc_app_ctrl_reg.sv
module sim_intc_app_ctrl_reg;
  typedef struct packed {
    logic        sec;
    logic [31:0] data;
    logic        pulse;
    logic        upd;
    logic [31:0] expS;
    logic [31:0] expN;
    logic [7:0]  mask;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h05FA_0300, 1'b0, 1'b1, 32'hFA05_0000, 32'hFA05_0300, 8'hF0}, // R3
    '{1'b1, 32'h05FA_6508, 1'b0, 1'b1, 32'hFA05_6508, 32'hFA05_2300, 8'hF0}, // R4 R6
    '{1'b0, 32'h05FA_0104, 1'b0, 1'b1, 32'hFA05_6508, 32'hFA05_2100, 8'hFC}, // R5 blocked, R4
    '{1'b0, 32'h1234_0704, 1'b0, 1'b0, 32'hFA05_6508, 32'hFA05_2100, 8'hFC}, // R1
    '{1'b1, 32'h05FA_0204, 1'b1, 1'b1, 32'hFA05_0200, 32'hFA05_0100, 8'hFC}, // R5 secure
    '{1'b0, 32'h05FA_0004, 1'b1, 1'b1, 32'hFA05_0200, 32'hFA05_0000, 8'hFE}, // R5 ns allowed
    '{1'b1, 32'h05FA_F7F3, 1'b0, 1'b1, 32'hFA05_6700, 32'hFA05_2000, 8'hFE}, // R9 R10
    '{1'b1, 32'h05FB_0000, 1'b0, 1'b0, 32'hFA05_6700, 32'hFA05_2000, 8'hFE}, // R1
    '{1'b0, 32'h05FA_0700, 1'b0, 1'b1, 32'hFA05_6700, 32'hFA05_2700, 8'h00}  // R8
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, secAttr = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sysResetReq, prioUpdate;
  logic [7:0]  prioMask;
  logic        wrEn1 = 1'b0, secAttr1 = 1'b0;
  logic [31:0] wrData1 = '0;
  logic [31:0] rdData1;
  logic        sysResetReq1, prioUpdate1;
  logic [7:0]  prioMask1;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  intc_app_ctrl_reg u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .secAttr(secAttr), .wrData(wrData),
    .rdData(rdData), .sysResetReq(sysResetReq), .prioUpdate(prioUpdate), .prioMask(prioMask)
  );

  intc_app_ctrl_reg #(.HAS_SECURITY(1'b0), .IS_V8(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn1), .secAttr(secAttr1), .wrData(wrData1),
    .rdData(rdData1), .sysResetReq(sysResetReq1), .prioUpdate(prioUpdate1), .prioMask(prioMask1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readBoth(output logic [31:0] rs, output logic [31:0] rn);
    secAttr = 1'b1; #1 rs = rdData;
    secAttr = 1'b0; #1 rn = rdData;
  endtask

  task automatic doWrite(input logic sec, input logic [31:0] d,
                         output logic pulse, output logic upd);
    @(negedge clk);
    secAttr = sec; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    pulse = sysResetReq; upd = prioUpdate;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rs, rn;
    logic p, u;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state, R2 key field, R8 mask at grouping 0
    readBoth(rs, rn);
    check("R7 secure read after reset", rs, 32'hFA05_0000);
    check("R7 ns read after reset", rn, 32'hFA05_0000);
    check("R8 mask after reset", {24'h0, prioMask}, 32'hFE);
    check("R11 idle strobe", {31'h0, prioUpdate}, 32'h0);
    check("R7 nosec fault bit reads one", rdData1, 32'hFA05_2000);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i].sec, VEC[i].data, p, u);
      check($sformatf("R5 pulse vec%0d", i), {31'h0, p}, {31'h0, VEC[i].pulse});
      check($sformatf("R11 strobe vec%0d", i), {31'h0, u}, {31'h0, VEC[i].upd});
      readBoth(rs, rn);
      check($sformatf("R2 R3 R6 secure read vec%0d", i), rs, VEC[i].expS);
      check($sformatf("R2 R3 R6 ns read vec%0d", i), rn, VEC[i].expN);
      check($sformatf("R8 mask vec%0d", i), {24'h0, prioMask}, {24'h0, VEC[i].mask});
      @(negedge clk);
      check($sformatf("R5 pulse one cycle vec%0d", i), {31'h0, sysResetReq}, 32'h0);
      check($sformatf("R11 strobe one cycle vec%0d", i), {31'h0, prioUpdate}, 32'h0);
    end

    // R9: clear-active and vector-reset bits alone cause no pulse and no change
    doWrite(1'b0, 32'h05FA_0703, p, u);
    check("R9 no pulse for bits 1:0", {31'h0, p}, 32'h0);
    readBoth(rs, rn);
    check("R9 ns read unchanged", rn, 32'hFA05_2700);

    // R4/R7: without security, a write with the secure attribute cannot clear bit 13
    @(negedge clk);
    secAttr1 = 1'b1; wrData1 = 32'h05FA_0500; wrEn1 = 1'b1;
    @(negedge clk);
    wrEn1 = 1'b0; secAttr1 = 1'b0;
    #1 check("R4 R7 nosec bit13 kept, grouping written", rdData1, 32'hFA05_2500);

    // R7: reset mid-run restores reset values
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readBoth(rs, rn);
    check("R7 secure read after second reset", rs, 32'hFA05_0000);
    check("R7 ns read after second reset", rn, 32'hFA05_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule